// File: doc/BRIEF.md
# Configuration memory readout sequencer

This block streams a fixed image out of an on-chip read-only array to a device that loads its configuration from it. The image is sent either as one bit per clock on lane 0 or as one byte per clock on all eight lanes. An address counter moves through the array only while every enable agrees. Chip enable, the active-low output-enable/reset and the configuration pulse input decide when it runs. In byte mode, a busy input from the receiver also stalls it.

The array is split into equal revision slices, each with its own start address and terminal count. A rising edge on the configuration pulse input samples the revision select and restarts the stream at that slice. When the selected slice has been fully sent, the block disables its lanes, freezes its counter and pulls the cascade chip-enable low. That hands the stream to the next memory in a chain. After power-up, the block pulls its own output-enable/reset line low for a fixed number of cycles.

Top module: `cfg_stream_seq`

## Requirements
- R1: While rst_ni is low and for POR_CYCLES (default 4) rising clock edges after it rises, oe_pull_o is 1, all lanes are disabled (data_oe_o = 0) and ceo_no is 1. After that, oe_pull_o is 0.
- R2: While ce_ni is 1, data_oe_o is 0, data_o is 0 and ceo_no is 1. A clock edge with ce_ni high returns the counter to the start of the latched revision.
- R3: While oe_ni is 0, data_oe_o is 0 and ceo_no is 1. A clock edge with oe_ni low returns the counter to the start of the latched revision.
- R4: A rising clock edge advances the stream only if ce_ni is 0, oe_ni is 1, the power-on hold is over and cf_i is 1. In byte mode, busy_i must also be 0. In bit mode, busy_i has no effect.
- R5: A clock edge where cf_i is 1 and was 0 at the previous edge latches rev_sel_i and loads address rev_sel_i*(DEPTH/NUM_REV), with bit position 0. A change of rev_sel_i without such an edge has no effect.
- R6: In byte mode (par_mode_i = 1), an enabled stream drives data_oe_o = 8'hFF and data_o = the array byte at the current address. The byte at address a is (37*a + 5) mod 256.
- R7: In bit mode (par_mode_i = 0), data_oe_o = 8'h01 and data_o[7:1] = 0. data_o[0] carries the current byte most significant bit first, one bit per advancing edge. The address steps after the eighth bit.
- R8: An advancing edge that consumes the last unit at the slice's terminal count (start + DEPTH/NUM_REV - 1) sets the block done. The unit is the byte in byte mode and bit 0 in bit mode. While done, data_oe_o is 0, the counter holds, and ceo_no is 0 when ce_ni is 0 and oe_ni is 1. A reset, a CE deassertion, an oe_ni low or a cf_i reload clears done.
- R9: ceo_no returns to 1 in the same cycle that ce_ni rises or oe_ni falls, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable / counter reset, active low |
| cf_i | input | 1 | Configuration pulse; rising edge reloads the revision start |
| busy_i | input | 1 | Receiver busy, honoured in byte mode |
| par_mode_i | input | 1 | 1 = byte mode, 0 = bit mode |
| rev_sel_i | input | RW | Revision select, sampled on a cf_i rise |
| data_o | output | 8 | Data lanes |
| data_oe_o | output | 8 | Per-lane drive enable |
| ceo_no | output | 1 | Cascade chip enable to the next memory, active low |
| oe_pull_o | output | 1 | Pull-down request on the output-enable line during power-on hold |

## Verification
The assertions assume that ce_ni, oe_ni, cf_i, busy_i and par_mode_i only change between clock edges, and that par_mode_i is held steady while a stall or a done hold is being judged. The stall and freeze properties compare the counter across one edge and exclude edges with a cf_i rise or an active reset condition. The bench therefore changes inputs only at falling edges and switches mode only while the counter is parked by oe_ni or at a fresh start. It also pulses cf_i low for a full cycle, so that every reload comes from a clean rise.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

  typedef enum logic {
    MODE_BIT  = 1'b0,
    MODE_BYTE = 1'b1
  } lane_mode_e;

  // array contents: affine map, odd multiplier keeps every byte distinct
  function automatic logic [7:0] rom_byte(input int unsigned addr);
    logic [31:0] v;
    v = addr * 32'd37 + 32'd5;
    return v[7:0];
  endfunction

endpackage

// File: rtl/cfg_por_gen.sv
module cfg_por_gen #(
  parameter int unsigned POR_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic por_o
);
  localparam int unsigned CW = $clog2(POR_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (cnt_q != CW'(POR_CYCLES)) cnt_q <= cnt_q + 1'b1;
  end

  assign por_o = (cnt_q != CW'(POR_CYCLES));
endmodule

// File: rtl/cfg_rev_table.sv
module cfg_rev_table #(
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned NUM_REV = 4,
  parameter int unsigned AW      = $clog2(DEPTH),
  parameter int unsigned RW      = (NUM_REV > 1) ? $clog2(NUM_REV) : 1
) (
  input  logic [RW-1:0] rev_i,
  output logic [AW-1:0] start_o,
  output logic [AW-1:0] tc_o
);
  localparam int unsigned SPAN = DEPTH / NUM_REV;

  logic [AW-1:0] start_tab [NUM_REV];
  logic [AW-1:0] tc_tab    [NUM_REV];

  for (genvar r = 0; r < NUM_REV; r++) begin : g_rev
    assign start_tab[r] = AW'(r * SPAN);
    assign tc_tab[r]    = AW'(r * SPAN + SPAN - 1);
  end

  always_comb begin
    start_o = '0;
    tc_o    = AW'(SPAN - 1);
    if (int'(rev_i) < NUM_REV) begin
      start_o = start_tab[rev_i];
      tc_o    = tc_tab[rev_i];
    end
  end
endmodule

// File: rtl/cfg_rom.sv
module cfg_rom #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic [AW-1:0] addr_i,
  output logic [7:0]    byte_o
);
  import cfg_stream_pkg::*;

  logic [7:0] mem [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_word
    assign mem[a] = rom_byte(a);
  end

  assign byte_o = (int'(addr_i) < DEPTH) ? mem[addr_i] : 8'h00;
endmodule

// File: rtl/cfg_addr_ctr.sv
module cfg_addr_ctr #(
  parameter int unsigned AW = 6,
  parameter int unsigned RW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,       // ce high, oe low or power-on hold
  input  logic          cf_i,
  input  logic          busy_i,
  input  logic          par_i,
  input  logic [RW-1:0] rev_sel_i,
  input  logic [AW-1:0] sel_start_i,  // start of rev_sel_i
  input  logic [AW-1:0] cur_start_i,  // start of latched revision
  input  logic [AW-1:0] cur_tc_i,     // terminal count of latched revision
  output logic [RW-1:0] rev_o,
  output logic [AW-1:0] addr_o,
  output logic [2:0]    bit_o,
  output logic          done_o
);
  logic          cf_q;
  logic [RW-1:0] rev_q;
  logic [AW-1:0] addr_q;
  logic [2:0]    bit_q;
  logic          done_q;
  logic          cf_rise, adv, unit_end;

  assign cf_rise  = cf_i & ~cf_q;
  assign adv      = cf_i & ~done_q & (~par_i | ~busy_i);
  assign unit_end = par_i | (bit_q == 3'd7);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cf_q   <= 1'b1;
      rev_q  <= '0;
      addr_q <= '0;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cf_q <= cf_i;
      if (cf_rise) begin
        rev_q  <= rev_sel_i;
        addr_q <= sel_start_i;
        bit_q  <= '0;
        done_q <= 1'b0;
      end else if (hold_i) begin
        addr_q <= cur_start_i;
        bit_q  <= '0;
        done_q <= 1'b0;
      end else if (adv) begin
        bit_q <= par_i ? 3'd0 : bit_q + 3'd1;
        if (unit_end) begin
          if (addr_q == cur_tc_i) done_q <= 1'b1;
          else                    addr_q <= addr_q + 1'b1;
        end
      end
    end
  end

  assign rev_o  = rev_q;
  assign addr_o = addr_q;
  assign bit_o  = bit_q;
  assign done_o = done_q;
endmodule

// File: rtl/cfg_stream_seq.sv
module cfg_stream_seq #(
  parameter int unsigned DEPTH      = 64,
  parameter int unsigned NUM_REV    = 4,
  parameter int unsigned POR_CYCLES = 4,
  parameter int unsigned RW         = (NUM_REV > 1) ? $clog2(NUM_REV) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic          cf_i,
  input  logic          busy_i,
  input  logic          par_mode_i,
  input  logic [RW-1:0] rev_sel_i,
  output logic [7:0]    data_o,
  output logic [7:0]    data_oe_o,
  output logic          ceo_no,
  output logic          oe_pull_o
);
  import cfg_stream_pkg::*;

  localparam int unsigned AW = $clog2(DEPTH);

  logic          por;
  logic          oe_eff, selected, stream_on;
  logic [RW-1:0] rev_q;
  logic [AW-1:0] addr_q, sel_start, cur_start, cur_tc, unused_tc;
  logic [2:0]    bit_q;
  logic          done_q;
  logic [7:0]    rom_q;
  lane_mode_e    mode;

  assign mode = lane_mode_e'(par_mode_i);

  cfg_por_gen #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .por_o (por)
  );

  assign oe_eff   = oe_ni & ~por;
  assign selected = ~ce_ni & oe_eff;

  cfg_rev_table #(.DEPTH(DEPTH), .NUM_REV(NUM_REV), .AW(AW), .RW(RW)) u_tab_sel (
    .rev_i  (rev_sel_i),
    .start_o(sel_start),
    .tc_o   (unused_tc)
  );

  cfg_rev_table #(.DEPTH(DEPTH), .NUM_REV(NUM_REV), .AW(AW), .RW(RW)) u_tab_cur (
    .rev_i  (rev_q),
    .start_o(cur_start),
    .tc_o   (cur_tc)
  );

  cfg_addr_ctr #(.AW(AW), .RW(RW)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_i     (~selected),
    .cf_i       (cf_i),
    .busy_i     (busy_i),
    .par_i      (mode == MODE_BYTE),
    .rev_sel_i  (rev_sel_i),
    .sel_start_i(sel_start),
    .cur_start_i(cur_start),
    .cur_tc_i   (cur_tc),
    .rev_o      (rev_q),
    .addr_o     (addr_q),
    .bit_o      (bit_q),
    .done_o     (done_q)
  );

  cfg_rom #(.DEPTH(DEPTH), .AW(AW)) u_rom (
    .addr_i(addr_q),
    .byte_o(rom_q)
  );

  assign stream_on = selected & ~done_q;

  always_comb begin
    data_o    = 8'h00;
    data_oe_o = 8'h00;
    if (stream_on) begin
      if (mode == MODE_BYTE) begin
        data_o    = rom_q;
        data_oe_o = 8'hFF;
      end else begin
        data_o    = {7'b0, rom_q[3'd7 - bit_q]};
        data_oe_o = 8'h01;
      end
    end
  end

  assign ceo_no    = ~(selected & done_q);
  assign oe_pull_o = por;

  logic unused_ok;
  assign unused_ok = ^unused_tc;
endmodule

// File: rtl/cfg_stream_seq_chk.sv
module cfg_stream_seq_chk #(
  parameter int unsigned AW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ce_ni,
  input logic          oe_ni,
  input logic          cf_i,
  input logic          busy_i,
  input logic          par_mode_i,
  input logic [7:0]    data_oe_o,
  input logic          ceo_no,
  input logic          oe_pull_o,
  input logic [AW-1:0] addr_i
);
  // R1: power-on hold keeps lanes off
  p_por_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_pull_o |-> (data_oe_o == 8'h00) && ceo_no);

  // R2
  p_standby_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> (data_oe_o == 8'h00) && ceo_no);

  // R3
  p_oe_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_ni |-> (data_oe_o == 8'h00) && ceo_no);

  // R4: byte mode stall on busy
  p_busy_stall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_mode_i && busy_i && !ce_ni && oe_ni && !oe_pull_o && cf_i && !$rose(cf_i))
    |=> $stable(addr_i));

  // R4: cf low stalls
  p_cf_stall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cf_i && !ce_ni && oe_ni && !oe_pull_o) |=> $stable(addr_i));

  // R6
  p_byte_lanes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_mode_i && data_oe_o != 8'h00) |-> data_oe_o == 8'hFF);

  // R7
  p_bit_lanes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !par_mode_i |-> (data_oe_o & 8'hFE) == 8'h00);

  // R8: cascade low implies lanes off and counter frozen
  p_done_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ceo_no |-> data_oe_o == 8'h00);

  p_done_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ceo_no && cf_i && !$rose(cf_i) && !ce_ni && oe_ni && !oe_pull_o)
    |=> $stable(addr_i));
endmodule

bind cfg_stream_seq cfg_stream_seq_chk #(.AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ce_ni     (ce_ni),
  .oe_ni     (oe_ni),
  .cf_i      (cf_i),
  .busy_i    (busy_i),
  .par_mode_i(par_mode_i),
  .data_oe_o (data_oe_o),
  .ceo_no    (ceo_no),
  .oe_pull_o (oe_pull_o),
  .addr_i    (addr_q)
);

// File: tb/cfg_stream_seq_test.sv
`timescale 1ns/1ps
module cfg_stream_seq_test;
  localparam int unsigned DEPTH = 64;
  localparam int unsigned NREV  = 4;
  localparam int unsigned SPAN  = DEPTH / NREV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1, oe_n = 1'b1, cf = 1'b1, busy = 1'b0, par = 1'b1;
  logic [1:0] rev = 2'd0;
  logic [7:0] data, data_oe;
  logic       ceo_n, oe_pull;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cfg_stream_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .cf_i(cf),
    .busy_i(busy), .par_mode_i(par), .rev_sel_i(rev),
    .data_o(data), .data_oe_o(data_oe), .ceo_no(ceo_n), .oe_pull_o(oe_pull)
  );

  function automatic logic [7:0] img(input int a);
    return 8'((37 * a + 5) % 256);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_byte(input int a, input string req);
    chk(data_oe == 8'hFF, req, data_oe, 8'hFF);
    chk(data == img(a), req, data, img(a));
  endtask

  task automatic chk_bit(input int a, input int b, input string req);
    chk(data_oe == 8'h01, req, data_oe, 8'h01);
    chk(data == {7'b0, img(a)[7-b]}, req, data, {7'b0, img(a)[7-b]});
  endtask

  task automatic chk_off(input bit ceo_exp, input string req);
    chk(data_oe == 8'h00, req, data_oe, 0);
    chk(ceo_n == ceo_exp, req, ceo_n, ceo_exp);
  endtask

  task automatic reload(input logic [1:0] r);
    cf = 1'b0; rev = r;
    step(1);
    cf = 1'b1;
    step(1);
  endtask

  task automatic t_reset;
    #1;
    chk(oe_pull == 1'b1, "R1 pull in reset", oe_pull, 1);
    chk_off(1'b1, "R1 reset");
    step(1);
    rst_n = 1'b1;
    ce_n = 1'b0;
    for (int i = 1; i <= 3; i++) begin
      step(1);
      chk(oe_pull == 1'b1, "R1 pull during hold", oe_pull, 1);
      chk_off(1'b1, "R1 hold");
    end
    step(1);
    chk(oe_pull == 1'b0, "R1 pull released", oe_pull, 0);
  endtask

  task automatic t_byte_stream;
    chk_byte(0, "R6 first byte");
    for (int i = 1; i <= 5; i++) begin
      step(1);
      chk_byte(i, "R6 byte stream");
    end
  endtask

  task automatic t_busy;
    busy = 1'b1;
    step(3);
    chk_byte(5, "R4 busy stalls byte mode");
    busy = 1'b0;
    step(1);
    chk_byte(6, "R4 advance after busy");
  endtask

  task automatic t_cf;
    cf = 1'b0;
    step(2);
    chk_byte(6, "R4 cf low stalls");
    cf = 1'b1; rev = 2'd2;
    step(1);
    chk_byte(2 * SPAN, "R5 cf rise loads rev 2");
    rev = 2'd3;
    step(1);
    chk_byte(2 * SPAN + 1, "R5 rev change ignored");
  endtask

  task automatic t_tc_byte;
    step(SPAN - 2);
    chk_byte(3 * SPAN - 1, "R8 at terminal count");
    chk(ceo_n == 1'b1, "R8 ceo before tc", ceo_n, 1);
    step(1);
    chk_off(1'b0, "R8 past terminal count");
    step(2);
    chk_off(1'b0, "R8 stays done");
    ce_n = 1'b1;
    #1;
    chk_off(1'b1, "R9 ceo on ce high");
    chk(data == 8'h00, "R2 data zero in standby", data, 0);
    step(1);
    ce_n = 1'b0;
    #1;
    chk_byte(2 * SPAN, "R2 restart at rev start");
  endtask

  task automatic t_oe;
    step(SPAN);
    chk_off(1'b0, "R8 done again");
    oe_n = 1'b0;
    #1;
    chk_off(1'b1, "R9 ceo on oe low");
    step(1);
    chk_off(1'b1, "R3 oe low");
    par = 1'b0;
    busy = 1'b1;
    step(1);
    oe_n = 1'b1;
    #1;
    chk_bit(2 * SPAN, 0, "R3 restart at rev start");
  endtask

  task automatic t_serial;
    for (int b = 1; b < 8; b++) begin
      step(1);
      chk_bit(2 * SPAN, b, "R7 msb first, busy ignored R4");
    end
    step(1);
    chk_bit(2 * SPAN + 1, 0, "R7 address after eighth bit");
    busy = 1'b0;
    reload(2'd3);
    chk_bit(3 * SPAN, 0, "R5 reload in bit mode");
    step(SPAN * 8 - 1);
    chk_bit(4 * SPAN - 1, 7, "R8 last bit");
    chk(ceo_n == 1'b1, "R8 ceo on last bit", ceo_n, 1);
    step(1);
    chk_off(1'b0, "R8 bit mode done");
    step(3);
    chk_off(1'b0, "R8 bit mode frozen");
    reload(2'd1);
    chk(ceo_n == 1'b1, "R8 cf clears done", ceo_n, 1);
    chk_bit(SPAN, 0, "R5 reload rev 1");
  endtask

  initial begin
    t_reset();
    t_byte_stream();
    t_busy();
    t_cf();
    t_tc_byte();
    t_oe();
    t_serial();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule